// File: doc/BRIEF.md
# Half-Precision to 8-bit Float Converter with Offset Pre-Add

This block turns one IEEE half-precision word into an 8-bit floating-point code. Two target layouts are available: a 5-bit-exponent / 2-bit-mantissa layout (E5M2, exponent bias 15, with infinities) and a 4-bit-exponent / 3-bit-mantissa layout (E4M3, exponent bias 7, no infinity). Dropped mantissa bits are rounded to nearest, ties to even. Magnitudes below half of the smallest target subnormal become signed zero. Target subnormals are produced with the same rounding.

Before conversion, an optional 8-bit offset is added to the raw 16-bit pattern of the input, not to its numeric value. The add wraps modulo 2^16. For E5M2 the offset is zero-extended. For E4M3 it is first shifted right by one bit. Each request also chooses how overflow is handled. The saturating choice clamps to the largest finite code. The non-saturating choice produces the format's overflow code.

A request is taken when `in_valid` is high. The block is a two-register pipeline: the offset add is registered, then the conversion is registered. One request per cycle is accepted, with no stall.

Top module: `fp8cv_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_code` are 0.
- R2: `out_valid` is high exactly two clock edges after each cycle with `in_valid` high, and low otherwise. Back-to-back requests come out in order, one per cycle.
- R3: With `in_fmt`=0 (E5M2), finite in-range inputs give `{sign, exp[4:0], man[1:0]}` rounded to nearest-even (1.0 gives 0x3C).
- R4: With `in_fmt`=1 (E4M3), finite in-range inputs give `{sign, exp[3:0], man[2:0]}` rounded to nearest-even (1.0 gives 0x38; 448 gives 0x7E). Rounding may carry into the next exponent.
- R5: Inputs smaller than the target's smallest normal give target subnormals with nearest-even rounding. Inputs below half the smallest subnormal, and ties at that half, give signed zero (0x00 or 0x80).
- R6: With `in_sat`=1, an input that rounds above the largest finite value, or is an infinity, gives the largest finite code with the input sign: 0x7B/0xFB for E5M2, 0x7E/0xFE for E4M3.
- R7: With `in_sat`=0, such an input gives 0x7C/0xFC (infinity) for E5M2 and 0x7F/0xFF for E4M3.
- R8: A NaN input (exponent all ones, nonzero mantissa, after the offset add) gives 0x7E for E5M2 whatever its sign, and `{sign,7'h7F}` for E4M3.
- R9: With `in_bias_en`=1 and E5M2, the converted word is `in_half + {8'h00,in_bias}` modulo 2^16.
- R10: With `in_bias_en`=1 and E4M3, the converted word is `in_half + (in_bias >> 1)` modulo 2^16.
- R11: With `in_bias_en`=0, `in_bias` has no effect on `out_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_half | input | 16 | Half-precision input word |
| in_bias | input | 8 | Offset added to the raw input pattern |
| in_bias_en | input | 1 | 1 adds the offset, 0 converts the plain input |
| in_fmt | input | 1 | 0 selects E5M2, 1 selects E4M3 |
| in_sat | input | 1 | 1 saturates on overflow, 0 gives the overflow code |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_code | output | 8 | 8-bit float result |

## Verification
The assertions assume that every request input is at a known value on the edge where `in_valid` is high. The format and saturate checks look back two edges at `in_fmt` and `in_sat`, so they rely on the sampled request fields belonging to the result that appears. The bench changes inputs only on the falling edge and drives all request fields to zero between requests. Reset is held low from time zero, so the checks never see an unknown request.

// File: rtl/fp8cv_pkg.sv
package fp8cv_pkg;
    localparam int HALF_W  = 16;
    localparam int HEXP_W  = 5;
    localparam int HMAN_W  = 10;
    localparam int HBIAS   = 15;
    localparam int OFS_W   = 8;
    localparam int CODE_W  = 8;
    localparam int NUM_FMT = 2;

    typedef enum logic {
        FMT_E5M2 = 1'b0,
        FMT_E4M3 = 1'b1
    } fp8_fmt_e;

    typedef struct packed {
        logic [HALF_W-1:0] word;
        fp8_fmt_e          fmt;
        logic              sat;
    } stage_t;
endpackage

// File: rtl/fp8cv_offset_add.sv
module fp8cv_offset_add
    import fp8cv_pkg::*;
(
    input  logic [HALF_W-1:0] half_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              ofs_en_i,
    input  fp8_fmt_e          fmt_i,
    output logic [HALF_W-1:0] word_o
);
    logic [HALF_W-1:0] addend;

    always_comb begin
        addend = '0;
        if (ofs_en_i) begin
            if (fmt_i == FMT_E4M3) addend = HALF_W'(ofs_i >> 1);
            else                   addend = HALF_W'(ofs_i);
        end
        word_o = half_i + addend;
    end
endmodule

// File: rtl/fp8cv_encode.sv
module fp8cv_encode
    import fp8cv_pkg::*;
#(
    parameter int EXP_W   = 5,
    parameter int MAN_W   = 2,
    parameter bit HAS_INF = 1'b1
) (
    input  logic [HALF_W-1:0] half_i,
    input  logic              sat_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int TBIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMIN    = 1 - TBIAS;
    localparam int MAX_FIN = HAS_INF ? ((((1 << EXP_W) - 1) << MAN_W) - 1)
                                     : ((1 << (EXP_W + MAN_W)) - 2);
    localparam int OVF_MAG = HAS_INF ? (((1 << EXP_W) - 1) << MAN_W)
                                     : ((1 << (EXP_W + MAN_W)) - 1);
    localparam int NAN_MAG = HAS_INF ? (OVF_MAG + (1 << (MAN_W - 1))) : OVF_MAG;
    localparam int SH_BASE = HMAN_W - MAN_W;
    localparam int SH_CAP  = HMAN_W + 2;
    localparam int SIG_W   = HMAN_W + 1;
    localparam int EXT_W   = SIG_W + SH_CAP;

    logic              sign;
    logic [HEXP_W-1:0] hexp;
    logic [HMAN_W-1:0] hman;
    logic              is_nan;
    logic              is_inf;
    logic [SIG_W-1:0]  sig;
    int                e_unb;
    int                e_eff;
    int                sh_i;
    int                mag;
    logic [EXT_W-1:0]  ext;
    logic [SIG_W-1:0]  kept;
    logic              rbit;
    logic              sticky;
    logic [SIG_W:0]    rnd;

    always_comb begin
        sign   = half_i[HALF_W-1];
        hexp   = half_i[HALF_W-2 -: HEXP_W];
        hman   = half_i[HMAN_W-1:0];
        is_nan = (&hexp) && (|hman);
        is_inf = (&hexp) && !(|hman);
        sig    = {(hexp != '0), hman};
        e_unb  = (hexp == '0) ? (1 - HBIAS) : (int'(hexp) - HBIAS);
        e_eff  = (e_unb < EMIN) ? EMIN : e_unb;
        sh_i   = SH_BASE + e_eff - e_unb;
        if (sh_i > SH_CAP) sh_i = SH_CAP;
        ext    = {sig, {SH_CAP{1'b0}}} >> sh_i;
        kept   = ext[EXT_W-1 -: SIG_W];
        rbit   = ext[SH_CAP-1];
        sticky = |ext[SH_CAP-2:0];
        rnd    = {1'b0, kept} + (SIG_W+1)'(rbit & (sticky | kept[0]));
        mag    = ((e_eff + TBIAS - 1) << MAN_W) + int'(rnd);
        if (is_nan) begin
            if (HAS_INF) code_o = CODE_W'(NAN_MAG);
            else         code_o = {sign, (CODE_W-1)'(NAN_MAG)};
        end else if (is_inf || (mag > MAX_FIN)) begin
            code_o = {sign, (CODE_W-1)'(sat_i ? MAX_FIN : OVF_MAG)};
        end else begin
            code_o = {sign, (CODE_W-1)'(mag)};
        end
    end
endmodule

// File: rtl/fp8cv_top.sv
module fp8cv_top
    import fp8cv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_half,
    input  logic [OFS_W-1:0]  in_bias,
    input  logic              in_bias_en,
    input  logic              in_fmt,
    input  logic              in_sat,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);
    fp8_fmt_e          req_fmt;
    logic [HALF_W-1:0] sum_word;
    stage_t            s1_q;
    logic              s1_valid_q;
    logic [CODE_W-1:0] fmt_code [NUM_FMT];

    assign req_fmt = fp8_fmt_e'(in_fmt);

    fp8cv_offset_add u_ofs (
        .half_i   (in_half),
        .ofs_i    (in_bias),
        .ofs_en_i (in_bias_en),
        .fmt_i    (req_fmt),
        .word_o   (sum_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid_q <= 1'b0;
            s1_q       <= '0;
        end else begin
            s1_valid_q <= in_valid;
            if (in_valid) begin
                s1_q.word <= sum_word;
                s1_q.fmt  <= req_fmt;
                s1_q.sat  <= in_sat;
            end
        end
    end

    for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
        localparam int FEXP = (f == int'(FMT_E5M2)) ? 5 : 4;
        localparam int FMAN = CODE_W - 1 - FEXP;
        fp8cv_encode #(
            .EXP_W   (FEXP),
            .MAN_W   (FMAN),
            .HAS_INF (f == int'(FMT_E5M2))
        ) u_enc (
            .half_i (s1_q.word),
            .sat_i  (s1_q.sat),
            .code_o (fmt_code[f])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= s1_valid_q;
            if (s1_valid_q) out_code <= fmt_code[int'(s1_q.fmt)];
        end
    end
endmodule

// File: rtl/fp8cv_chk.sv
module fp8cv_chk
    import fp8cv_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [HALF_W-1:0] in_half,
    input logic              in_bias_en,
    input logic              in_fmt,
    input logic              in_sat,
    input logic              out_valid,
    input logic [CODE_W-1:0] out_code
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    always @(negedge clk) begin
        if (!rst_n) AST_RESET_QUIET: assert (out_valid == 1'b0 && out_code == '0); // R1
    end

    AST_VALID_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

    AST_SAT_NEVER_INF: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && out_valid && $past(in_sat, 2) && !$past(in_fmt, 2))
        |-> (out_code[CODE_W-2:0] != 7'h7C)); // R6

    AST_E5M2_NAN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && out_valid && !$past(in_fmt, 2) && out_code[CODE_W-2:2] == 5'h1F
         && out_code[1:0] != 2'b00) |-> (out_code == 8'h7E)); // R8

    AST_ZERO_KEEPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && out_valid && !$past(in_bias_en, 2) && $past(in_half[HALF_W-2:0], 2) == '0)
        |-> (out_code == {$past(in_half[HALF_W-1], 2), 7'h00})); // R5
endmodule

bind fp8cv_top fp8cv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_half    (in_half),
    .in_bias_en (in_bias_en),
    .in_fmt     (in_fmt),
    .in_sat     (in_sat),
    .out_valid  (out_valid),
    .out_code   (out_code)
);

// File: tb/fp8cv_top_tb_top.sv
`timescale 1ns/1ps
module fp8cv_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic [7:0]  in_bias = '0;
    logic        in_bias_en = 1'b0;
    logic        in_fmt = 1'b0;
    logic        in_sat = 1'b0;
    logic        out_valid;
    logic [7:0]  out_code;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fp8cv_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
        .in_bias(in_bias), .in_bias_en(in_bias_en), .in_fmt(in_fmt),
        .in_sat(in_sat), .out_valid(out_valid), .out_code(out_code)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] h, input logic [7:0] b, input logic en,
                         input logic f, input logic s);
        in_valid = 1'b1; in_half = h; in_bias = b; in_bias_en = en; in_fmt = f; in_sat = s;
    endtask

    task automatic idle();
        in_valid = 1'b0; in_half = '0; in_bias = '0; in_bias_en = 1'b0; in_fmt = 1'b0; in_sat = 1'b0;
    endtask

    task automatic conv(input string req, input logic [15:0] h, input logic [7:0] b,
                        input logic en, input logic f, input logic s, input logic [7:0] exp);
        @(negedge clk) drive(h, b, en, f, s);
        @(negedge clk) idle();
        @(negedge clk) check(req, {out_valid, out_code}, {1'b1, exp});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset", {out_valid, out_code}, 9'h000);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) check("R2 idle", {8'h00, out_valid}, 9'h000);
    endtask

    task automatic t_e5m2_round();
        conv("R3 one",       16'h3C00, 8'h00, 0, 0, 0, 8'h3C);
        conv("R3 tie even",  16'h3C80, 8'h00, 0, 0, 0, 8'h3C);
        conv("R3 tie odd",   16'h3D80, 8'h00, 0, 0, 0, 8'h3E);
        conv("R3 above half",16'h3C81, 8'h00, 0, 0, 0, 8'h3D);
        conv("R3 top",       16'h7B7F, 8'h00, 0, 0, 0, 8'h7B);
        conv("R3 min normal",16'h0400, 8'h00, 0, 0, 0, 8'h04);
    endtask

    task automatic t_e4m3_round();
        conv("R4 one",       16'h3C00, 8'h00, 0, 1, 0, 8'h38);
        conv("R4 tie even",  16'h3C40, 8'h00, 0, 1, 0, 8'h38);
        conv("R4 tie odd",   16'h3CC0, 8'h00, 0, 1, 0, 8'h3A);
        conv("R4 max 448",   16'h5F00, 8'h00, 0, 1, 0, 8'h7E);
        conv("R4 464 to even",16'h5F40, 8'h00, 0, 1, 0, 8'h7E);
        conv("R4 carry exp", 16'h23FF, 8'h00, 0, 1, 0, 8'h08);
    endtask

    task automatic t_subnormal();
        conv("R5 e4m3 min sub",  16'h1800, 8'h00, 0, 1, 0, 8'h01);
        conv("R5 e4m3 two sub",  16'h1C00, 8'h00, 0, 1, 0, 8'h02);
        conv("R5 e4m3 three",    16'h1E00, 8'h00, 0, 1, 0, 8'h03);
        conv("R5 e4m3 half tie", 16'h1400, 8'h00, 0, 1, 0, 8'h00);
        conv("R5 e4m3 over half",16'h1401, 8'h00, 0, 1, 0, 8'h01);
        conv("R5 e4m3 neg zero", 16'h9400, 8'h00, 0, 1, 0, 8'h80);
        conv("R5 e4m3 tiny",     16'h0001, 8'h00, 0, 1, 0, 8'h00);
        conv("R5 e5m2 sub",      16'h00C0, 8'h00, 0, 0, 0, 8'h01);
        conv("R5 e5m2 neg sub",  16'h80C0, 8'h00, 0, 0, 0, 8'h81);
        conv("R5 e5m2 tie zero", 16'h0080, 8'h00, 0, 0, 0, 8'h00);
        conv("R5 e5m2 neg tiny", 16'h8001, 8'h00, 0, 0, 0, 8'h80);
    endtask

    task automatic t_overflow_sat();
        conv("R6 e5m2 round up", 16'h7B80, 8'h00, 0, 0, 1, 8'h7B);
        conv("R6 e5m2 neg inf",  16'hFC00, 8'h00, 0, 0, 1, 8'hFB);
        conv("R6 e4m3 over",     16'h5F41, 8'h00, 0, 1, 1, 8'h7E);
        conv("R6 e4m3 big neg",  16'hF000, 8'h00, 0, 1, 1, 8'hFE);
        conv("R6 e4m3 inf",      16'h7C00, 8'h00, 0, 1, 1, 8'h7E);
    endtask

    task automatic t_overflow_nonsat();
        conv("R7 e5m2 round up", 16'h7B80, 8'h00, 0, 0, 0, 8'h7C);
        conv("R7 e5m2 neg",      16'hFB80, 8'h00, 0, 0, 0, 8'hFC);
        conv("R7 e5m2 inf",      16'h7C00, 8'h00, 0, 0, 0, 8'h7C);
        conv("R7 e4m3 over",     16'h5F80, 8'h00, 0, 1, 0, 8'h7F);
        conv("R7 e4m3 neg inf",  16'hFC00, 8'h00, 0, 1, 0, 8'hFF);
    endtask

    task automatic t_nan();
        conv("R8 e5m2 nan",      16'h7E00, 8'h00, 0, 0, 0, 8'h7E);
        conv("R8 e5m2 neg nan",  16'hFE01, 8'h00, 0, 0, 1, 8'h7E);
        conv("R8 e4m3 nan",      16'h7E00, 8'h00, 0, 1, 1, 8'h7F);
        conv("R8 e4m3 neg nan",  16'hFE00, 8'h00, 0, 1, 0, 8'hFF);
    endtask

    task automatic t_bias_e5m2();
        conv("R9 add 0x81",      16'h3C00, 8'h81, 1, 0, 0, 8'h3D);
        conv("R9 wrap to tiny",  16'hFFFF, 8'h02, 1, 0, 0, 8'h00);
        conv("R9 into inf",      16'h7BFF, 8'h01, 1, 0, 0, 8'h7C);
    endtask

    task automatic t_bias_e4m3();
        conv("R10 halved 0xC2",  16'h3C00, 8'hC2, 1, 1, 0, 8'h39);
        conv("R10 halved 0x81",  16'h3C00, 8'h81, 1, 1, 0, 8'h38);
    endtask

    task automatic t_bias_off();
        conv("R11 e5m2 off",     16'h3C00, 8'h81, 0, 0, 0, 8'h3C);
        conv("R11 e4m3 off",     16'h3C00, 8'hC2, 0, 1, 0, 8'h38);
    endtask

    task automatic t_stream();
        @(negedge clk) drive(16'h3C00, 8'h00, 0, 0, 0);
        @(negedge clk) drive(16'h3C00, 8'h00, 0, 1, 0);
        @(negedge clk) begin
            check("R2 stream first", {out_valid, out_code}, 9'h13C);
            drive(16'h7E00, 8'h00, 0, 1, 0);
        end
        @(negedge clk) begin
            check("R2 stream second", {out_valid, out_code}, 9'h138);
            idle();
        end
        @(negedge clk) check("R2 stream third", {out_valid, out_code}, 9'h17F);
        @(negedge clk) check("R2 stream drained", {8'h00, out_valid}, 9'h000);
    endtask

    initial begin
        t_reset();
        t_e5m2_round();
        t_e4m3_round();
        t_subnormal();
        t_overflow_sat();
        t_overflow_nonsat();
        t_nan();
        t_bias_e5m2();
        t_bias_e4m3();
        t_bias_off();
        t_stream();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule